// File: doc/BRIEF.md
# Endpoint Buffer-Ready Interrupt Controller

This block keeps one buffer-ready flag for each data endpoint of a USB device controller (six by default) and drives one combined interrupt line. For every endpoint it watches a buffer-valid flag, a data-enable bit and a short-packet-drained event. It applies set and clear rules that depend on the endpoint's transfer direction and on whether the endpoint is the one bound to DMA. A buffer-clear strobe can force an endpoint's valid flag low.

A global ready-clear mode chooses how flags clear. In automatic mode a change of buffer state clears a flag. In software mode the CPU clears a flag by writing 0 to it. A per-endpoint enable register selects which flags reach the interrupt line. Each endpoint has its own two-state machine. EP_IDLE moves to EP_READY on the transition SET_EVT. EP_READY moves back to EP_IDLE on the transition CLR_EVT, which is an automatic clear or a software clear. SET_EVT wins when both occur in the same cycle.

Top module: `bri_irq_top`

## Requirements
- R1: While `rst_n` is 0, and at the first clock after it rises, `rdy_sts`, `irq_en` and `irq` are all 0.
- R2: An OUT endpoint (`ep_dir` bit 0) that is not DMA-quiet sets its flag on the clock after its effective valid flag goes from 0 to 1. DMA-quiet means the endpoint is DMA-selected and `dma_intm` is 0.
- R3: A DMA-quiet OUT endpoint ignores valid-flag rises. It sets its flag on the clock after a `short_drained` pulse, and only then.
- R4: With `rdy_mode` at 0, a flag clears on the clock after the effective valid flag falls (OUT endpoint) or rises (IN endpoint). A status write of 0 has no effect in this mode.
- R5: With `rdy_mode` at 1, valid-flag changes never clear a flag. A status write (`sts_wr`) clears each bit written as 0. Bits written as 1 are unchanged.
- R6: An IN endpoint (`ep_dir` bit 1) that is not DMA-quiet sets its flag on the clock after its effective valid flag falls, or after its `data_en` bit rises.
- R7: A DMA-quiet IN endpoint never sets its flag.
- R8: A `buf_clr` pulse forces the effective valid flag to 0 in that cycle. The flag stays at 0 until the raw `buf_valid` input has been 0 for a cycle and then rises again.
- R9: A set event and a status write of 0 to the same bit in the same cycle leave the bit at 1.
- R10: `irq` is 1 exactly when some bit is 1 in both `rdy_sts` and `irq_en`. `ien_wr` loads `irq_en` from `ien_wdata` on the next clock.
- R11: `dma_ep` value 0 selects no endpoint, and value k (1..6) selects endpoint k. Endpoint k is bit k-1 of every per-endpoint vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_dir | input | 6 | Direction per endpoint: 0 OUT, 1 IN |
| buf_valid | input | 6 | Raw buffer-valid flag per endpoint |
| data_en | input | 6 | Data-enable bit per endpoint |
| short_drained | input | 6 | Pulse: buffered data ending in a short packet fully read |
| buf_clr | input | 6 | Pulse: force the valid flag low |
| dma_ep | input | 3 | DMA-bound endpoint number, 0 for none |
| dma_intm | input | 1 | DMA interrupt mode |
| rdy_mode | input | 1 | 0 automatic clear, 1 software write-0 clear |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 6 | Status write data |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 6 | Enable write data |
| rdy_sts | output | 6 | Buffer-ready flags |
| irq_en | output | 6 | Interrupt enable register |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the buffer-clear mask. The mask has to outlive the `buf_clr` pulse while `buf_valid` stays high, and it has to be released only after `buf_valid` has been low for a cycle. The stimulus pulses `buf_clr` on a DMA-quiet OUT endpoint whose valid input is held high. It then waits several cycles before it drops and raises `buf_valid` again, and it repeats the sequence on an IN endpoint, where the forced fall sets the flag. A random phase then mixes clear strobes, DMA reselection and mode changes, and a behavioural model checks every cycle.

// File: rtl/bri_pkg.sv
package bri_pkg;
    typedef enum logic {
        EP_IDLE  = 1'b0,
        EP_READY = 1'b1
    } ep_state_e;
endpackage

// File: rtl/bri_vld_track.sv
module bri_vld_track #(
    parameter int NUM_EP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] buf_valid,
    input  logic [NUM_EP-1:0] buf_clr,
    input  logic [NUM_EP-1:0] data_en,
    output logic [NUM_EP-1:0] v_rise,
    output logic [NUM_EP-1:0] v_fall,
    output logic [NUM_EP-1:0] de_rise
);
    logic [NUM_EP-1:0] clr_mask_q;
    logic [NUM_EP-1:0] eff_valid;
    logic [NUM_EP-1:0] eff_valid_q;
    logic [NUM_EP-1:0] data_en_q;

    // mask survives the strobe until the raw valid input drops
    assign eff_valid = buf_valid & ~buf_clr & ~clr_mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_mask_q  <= '0;
            eff_valid_q <= '0;
            data_en_q   <= '0;
        end else begin
            clr_mask_q  <= (clr_mask_q | buf_clr) & buf_valid;
            eff_valid_q <= eff_valid;
            data_en_q   <= data_en;
        end
    end

    always_comb begin
        v_rise  = eff_valid & ~eff_valid_q;
        v_fall  = ~eff_valid & eff_valid_q;
        de_rise = data_en & ~data_en_q;
    end
endmodule

// File: rtl/bri_rule.sv
module bri_rule #(
    parameter int NUM_EP = 6,
    localparam int SELW = $clog2(NUM_EP + 1)
) (
    input  logic [NUM_EP-1:0] ep_dir,
    input  logic [NUM_EP-1:0] v_rise,
    input  logic [NUM_EP-1:0] v_fall,
    input  logic [NUM_EP-1:0] de_rise,
    input  logic [NUM_EP-1:0] short_drained,
    input  logic [SELW-1:0]   dma_ep,
    input  logic              dma_intm,
    input  logic              rdy_mode,
    input  logic              sts_wr,
    input  logic [NUM_EP-1:0] sts_wdata,
    output logic [NUM_EP-1:0] set_evt,
    output logic [NUM_EP-1:0] clr_evt
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic quiet;
        logic set_out;
        logic set_in;
        logic auto_clr;
        logic sw_clr;

        assign quiet = (dma_ep == SELW'(i + 1)) && !dma_intm;

        always_comb begin
            set_out  = quiet ? short_drained[i] : v_rise[i];
            set_in   = !quiet && (v_fall[i] || de_rise[i]);
            auto_clr = !rdy_mode && (ep_dir[i] ? v_rise[i] : v_fall[i]);
            sw_clr   = rdy_mode && sts_wr && !sts_wdata[i];
            set_evt[i] = ep_dir[i] ? set_in : set_out;
            clr_evt[i] = auto_clr || sw_clr;
        end
    end
endmodule

// File: rtl/bri_ep_fsm.sv
module bri_ep_fsm
    import bri_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic ready
);
    ep_state_e state_q;
    ep_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EP_IDLE:  if (set_evt) state_d = EP_READY;
            EP_READY: if (clr_evt && !set_evt) state_d = EP_IDLE;
            default:  state_d = EP_IDLE;
        endcase
    end

    always_comb begin
        ready = (state_q == EP_READY);
    end
endmodule

// File: rtl/bri_irq_top.sv
module bri_irq_top #(
    parameter int NUM_EP = 6,
    localparam int SELW = $clog2(NUM_EP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ep_dir,
    input  logic [NUM_EP-1:0] buf_valid,
    input  logic [NUM_EP-1:0] data_en,
    input  logic [NUM_EP-1:0] short_drained,
    input  logic [NUM_EP-1:0] buf_clr,
    input  logic [SELW-1:0]   dma_ep,
    input  logic              dma_intm,
    input  logic              rdy_mode,
    input  logic              sts_wr,
    input  logic [NUM_EP-1:0] sts_wdata,
    input  logic              ien_wr,
    input  logic [NUM_EP-1:0] ien_wdata,
    output logic [NUM_EP-1:0] rdy_sts,
    output logic [NUM_EP-1:0] irq_en,
    output logic              irq
);
    logic [NUM_EP-1:0] v_rise;
    logic [NUM_EP-1:0] v_fall;
    logic [NUM_EP-1:0] de_rise;
    logic [NUM_EP-1:0] set_evt;
    logic [NUM_EP-1:0] clr_evt;
    logic [NUM_EP-1:0] ien_q;

    bri_vld_track #(.NUM_EP(NUM_EP)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_valid (buf_valid),
        .buf_clr   (buf_clr),
        .data_en   (data_en),
        .v_rise    (v_rise),
        .v_fall    (v_fall),
        .de_rise   (de_rise)
    );

    bri_rule #(.NUM_EP(NUM_EP)) u_rule (
        .ep_dir        (ep_dir),
        .v_rise        (v_rise),
        .v_fall        (v_fall),
        .de_rise       (de_rise),
        .short_drained (short_drained),
        .dma_ep        (dma_ep),
        .dma_intm      (dma_intm),
        .rdy_mode      (rdy_mode),
        .sts_wr        (sts_wr),
        .sts_wdata     (sts_wdata),
        .set_evt       (set_evt),
        .clr_evt       (clr_evt)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_fsm
        bri_ep_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[i]),
            .clr_evt (clr_evt[i]),
            .ready   (rdy_sts[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    always_comb begin
        irq_en = ien_q;
        irq    = |(rdy_sts & ien_q);
    end
endmodule

// File: rtl/bri_irq_chk.sv
module bri_irq_chk #(
    parameter int NUM_EP = 6,
    localparam int SELW = $clog2(NUM_EP + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] ep_dir,
    input logic [NUM_EP-1:0] buf_valid,
    input logic [NUM_EP-1:0] buf_clr,
    input logic [SELW-1:0]   dma_ep,
    input logic              dma_intm,
    input logic              rdy_mode,
    input logic              sts_wr,
    input logic [NUM_EP-1:0] sts_wdata,
    input logic              ien_wr,
    input logic [NUM_EP-1:0] ien_wdata,
    input logic [NUM_EP-1:0] rdy_sts,
    input logic [NUM_EP-1:0] irq_en,
    input logic              irq
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rdy_sts == '0 && irq_en == '0));

    // R10
    a_r10_ien_load: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> irq_en == $past(ien_wdata));

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic quiet;
        assign quiet = (dma_ep == SELW'(i + 1)) && !dma_intm;

        // R2
        a_r2_out_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!ep_dir[i] && !quiet && buf_valid[i] && !$past(buf_valid[i]) && !buf_clr[i])
            |=> rdy_sts[i]);

        // R7
        a_r7_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_dir[i] && quiet && !rdy_sts[i]) |=> !rdy_sts[i]);

        // R5
        a_r5_mode1_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (rdy_mode && rdy_sts[i] && !(sts_wr && !sts_wdata[i])) |=> rdy_sts[i]);
    end
endmodule

bind bri_irq_top bri_irq_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_dir    (ep_dir),
    .buf_valid (buf_valid),
    .buf_clr   (buf_clr),
    .dma_ep    (dma_ep),
    .dma_intm  (dma_intm),
    .rdy_mode  (rdy_mode),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .ien_wr    (ien_wr),
    .ien_wdata (ien_wdata),
    .rdy_sts   (rdy_sts),
    .irq_en    (irq_en),
    .irq       (irq)
);

// File: tb/sim_bri_irq_top.sv
module sim_bri_irq_top;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ep_dir = '0, buf_valid = '0, data_en = '0;
    logic [N-1:0] short_drained = '0, buf_clr = '0;
    logic [2:0]   dma_ep = '0;
    logic         dma_intm = 1'b0, rdy_mode = 1'b0;
    logic         sts_wr = 1'b0, ien_wr = 1'b0;
    logic [N-1:0] sts_wdata = '0, ien_wdata = '0;
    logic [N-1:0] rdy_sts, irq_en;
    logic         irq;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit started = 0;

    // behavioural model state
    bit m_sts[N];
    bit m_ien[N];
    bit m_prev_v[N];
    bit m_prev_de[N];
    bit m_hold[N];

    always #5 clk = ~clk;

    bri_irq_top u0 (
        .clk(clk), .rst_n(rst_n), .ep_dir(ep_dir), .buf_valid(buf_valid),
        .data_en(data_en), .short_drained(short_drained), .buf_clr(buf_clr),
        .dma_ep(dma_ep), .dma_intm(dma_intm), .rdy_mode(rdy_mode),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .rdy_sts(rdy_sts), .irq_en(irq_en), .irq(irq)
    );

    always @(posedge clk) begin
        started <= 1;
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_sts[i] = 0; m_ien[i] = 0; m_prev_v[i] = 0;
                m_prev_de[i] = 0; m_hold[i] = 0;
            end else begin
                bit v, up, down, de_up, quiet, set, clr;
                v = buf_valid[i] && !buf_clr[i] && !m_hold[i];
                up = v && !m_prev_v[i];
                down = !v && m_prev_v[i];
                de_up = data_en[i] && !m_prev_de[i];
                quiet = (int'(dma_ep) == i + 1) && !dma_intm;
                if (ep_dir[i]) set = !quiet && (down || de_up);
                else if (quiet) set = short_drained[i];
                else set = up;
                clr = 0;
                if (!rdy_mode && ep_dir[i] && up) clr = 1;
                if (!rdy_mode && !ep_dir[i] && down) clr = 1;
                if (rdy_mode && sts_wr && !sts_wdata[i]) clr = 1;
                if (set) m_sts[i] = 1;
                else if (clr) m_sts[i] = 0;
                m_hold[i] = (m_hold[i] || buf_clr[i]) && buf_valid[i];
                m_prev_v[i] = v;
                m_prev_de[i] = data_en[i];
                if (ien_wr) m_ien[i] = ien_wdata[i];
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit any;
            any = 0;
            for (int i = 0; i < N; i++) begin
                total++;
                if (rdy_sts[i] !== m_sts[i]) begin
                    bad++;
                    $display("FAIL %s: rdy_sts[%0d] actual=%b expected=%b", cur_req, i, rdy_sts[i], m_sts[i]);
                end
                total++;
                if (irq_en[i] !== m_ien[i]) begin
                    bad++;
                    $display("FAIL R10: irq_en[%0d] actual=%b expected=%b", i, irq_en[i], m_ien[i]);
                end
                any = any | (m_sts[i] & m_ien[i]);
            end
            total++;
            if (irq !== any) begin
                bad++;
                $display("FAIL R10: irq actual=%b expected=%b", irq, any);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1", rdy_sts == '0 && irq_en == '0 && irq == 1'b0, 1'b1);
        rst_n = 1'b1;
        tick(1);
        chk("R1", rdy_sts == '0 && irq == 1'b0, 1'b1);

        cur_req = "R10";
        ien_wdata = '1; ien_wr = 1; tick(1); ien_wr = 0;
        chk("R10", irq_en == 6'h3f, 1'b1);

        cur_req = "R2";
        buf_valid[0] = 1; tick(1);
        chk("R2", rdy_sts[0], 1'b1);
        chk("R10", irq, 1'b1);
        cur_req = "R4";
        buf_valid[0] = 0; tick(1);
        chk("R4", rdy_sts[0], 1'b0);

        cur_req = "R11";
        dma_ep = 3'd1; dma_intm = 1; buf_valid[0] = 1; tick(1);
        chk("R11", rdy_sts[0], 1'b1);
        buf_valid[0] = 0; tick(1);

        cur_req = "R3";
        dma_intm = 0; buf_valid[0] = 1; tick(1);
        chk("R3", rdy_sts[0], 1'b0);
        short_drained[0] = 1; tick(1); short_drained[0] = 0;
        chk("R3", rdy_sts[0], 1'b1);
        tick(2);
        chk("R3", rdy_sts[0], 1'b1);

        cur_req = "R8";
        buf_clr[0] = 1; tick(1); buf_clr[0] = 0;
        chk("R8", rdy_sts[0], 1'b0);
        dma_intm = 1; tick(3);
        chk("R8", rdy_sts[0], 1'b0);
        buf_valid[0] = 0; tick(1);
        buf_valid[0] = 1; tick(1);
        chk("R8", rdy_sts[0], 1'b1);
        buf_valid[0] = 0; tick(1);
        dma_ep = 0;

        cur_req = "R6";
        ep_dir[1] = 1; buf_valid[1] = 1; tick(1);
        chk("R6", rdy_sts[1], 1'b0);
        buf_valid[1] = 0; tick(1);
        chk("R6", rdy_sts[1], 1'b1);
        buf_valid[1] = 1; tick(1);
        chk("R4", rdy_sts[1], 1'b0);
        data_en[1] = 1; tick(1);
        chk("R6", rdy_sts[1], 1'b1);
        data_en[1] = 0; buf_valid[1] = 0; tick(1);

        cur_req = "R7";
        buf_valid[1] = 1; tick(1);
        dma_ep = 3'd2; dma_intm = 0;
        buf_valid[1] = 0; tick(1);
        chk("R7", rdy_sts[1], 1'b0);
        data_en[1] = 1; tick(1);
        chk("R7", rdy_sts[1], 1'b0);
        data_en[1] = 0; dma_ep = 0; tick(1);

        cur_req = "R8";
        buf_valid[1] = 1; tick(1);
        buf_clr[1] = 1; tick(1); buf_clr[1] = 0;
        chk("R8", rdy_sts[1], 1'b1);
        buf_valid[1] = 0; tick(1);

        cur_req = "R4";
        sts_wdata = '0; sts_wr = 1; tick(1); sts_wr = 0;
        chk("R4", rdy_sts[1], 1'b1);

        cur_req = "R10";
        ien_wdata = '0; ien_wr = 1; tick(1); ien_wr = 0;
        chk("R10", irq, 1'b0);
        ien_wdata = '1; ien_wr = 1; tick(1); ien_wr = 0;
        chk("R10", irq, 1'b1);

        cur_req = "R5";
        rdy_mode = 1;
        buf_valid[2] = 1; tick(1);
        chk("R5", rdy_sts[2], 1'b1);
        buf_valid[2] = 0; tick(1);
        chk("R5", rdy_sts[2], 1'b1);
        buf_valid[1] = 1; tick(1);
        chk("R5", rdy_sts[1], 1'b1);
        sts_wdata = '1; sts_wr = 1; tick(1); sts_wr = 0;
        chk("R5", rdy_sts[2], 1'b1);
        sts_wdata = ~6'b000100; sts_wr = 1; tick(1); sts_wr = 0;
        chk("R5", rdy_sts[2], 1'b0);
        chk("R5", rdy_sts[1], 1'b1);

        cur_req = "R9";
        buf_valid[3] = 1; sts_wdata = '0; sts_wr = 1; tick(1); sts_wr = 0;
        chk("R9", rdy_sts[3], 1'b1);
        chk("R5", rdy_sts[1], 1'b0);

        cur_req = "R4";
        for (int c = 0; c < 600; c++) begin
            ep_dir = N'($urandom);
            if ($urandom_range(0, 3) == 0) buf_valid = buf_valid ^ N'($urandom);
            data_en = N'($urandom);
            short_drained = N'($urandom) & N'($urandom);
            buf_clr = ($urandom_range(0, 4) == 0) ? N'($urandom) & N'($urandom) : '0;
            if ($urandom_range(0, 15) == 0) dma_ep = 3'($urandom_range(0, 6));
            if ($urandom_range(0, 15) == 0) dma_intm = 1'($urandom);
            if ($urandom_range(0, 31) == 0) rdy_mode = 1'($urandom);
            sts_wr = ($urandom_range(0, 5) == 0);
            sts_wdata = N'($urandom);
            ien_wr = ($urandom_range(0, 9) == 0);
            ien_wdata = N'($urandom);
            tick(1);
        end
        sts_wr = 0; ien_wr = 0; tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule